// File: doc/BRIEF.md
# TCP Connection Supervisor

This block is the control core for a single TCP connection. It holds the connection's life-cycle state, takes open and close requests from the user side, reacts to abstracted events reported by a segment parser, and tells a segment builder which control segment to emit. Checksums, segment formatting and payload storage belong to neighbouring blocks. This block only decides what is sent and when.

All of its timing is done with tick counters on one clock:
- a deadline for completing the handshake or the close;
- a retransmission interval with a retry limit;
- an idle period before a liveness probe, and a shorter probe repeat interval with its own limit;
- a delay before a standalone acknowledgement of received data.

Every interval is a parameter in clock ticks, so a bench can shrink them. The five status outputs are one-hot and report idle, listening, connecting, connected or disconnecting.

A command is a one-cycle pulse on `cmd_valid` with a code on `cmd_code`. At most one command is issued per cycle. A timer that expires while a higher-priority command is being issued keeps its expiry and fires on a later cycle.

Top module: `tcp_conn_supervisor`

## Requirements
- R1: After reset, and on every cycle, exactly one of the five status outputs is high. Reset leaves the block idle with no command.
- R2: In idle, a listen request (without a connect request) moves to listening with no command and latches the local port. A SYN event then issues SYN-ACK and moves to connecting. An ACK event in that state moves to connected.
- R3: In idle, a connect request issues SYN, moves to connecting and latches the local port, remote address and remote port. If listen and connect are both requested, connect wins. A SYN-ACK event then issues ACK and moves to connected.
- R4: In connected, a close request or a FIN event issues FIN and moves to disconnecting. In disconnecting, a FIN event issues ACK and moves to idle, and an ACK event moves to idle with no command. A close request outside connected has no effect.
- R5: If the block stays in connecting or disconnecting for CONN_TICKS+1 cycles, it issues RST and returns to idle.
- R6: A segment is unacknowledged while the block is in connecting or disconnecting, or in connected with `seg_unacked` high. While one is unacknowledged, RETX is issued every RETX_TICKS+1 cycles. When the interval expires after RETX_TRIES retransmissions, RST is issued and the block returns to idle. An ACK event restarts the interval and the try count.
- R7: In connected with keepalive enabled, a probe is issued after KA_PERIOD+1 cycles without any received event. Any received event (SYN, SYN-ACK, ACK, FIN or data) restarts that period.
- R8: After the first probe, further probes follow every KA_INTERVAL+1 cycles until an event is received. When the interval expires after KA_TRIES repeat probes, RST is issued and the block returns to idle.
- R9: In connected, ACK is issued ACK_TICKS+1 cycles after the most recent data event. Each new data event restarts this delay.
- R10: A received RST in any state other than idle returns the block to idle on the next cycle, with no command.
- R11: Command codes on `cmd_code` are: 1 SYN, 2 SYN-ACK, 3 ACK, 4 FIN, 5 RST, 6 keepalive probe, 7 retransmit. `cmd_valid` is high exactly when a code is present, and an RST command always coincides with idle status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 125 MHz |
| rst_n | input | 1 | Synchronous reset, active low |
| req_listen | input | 1 | Open passively on `loc_port_i` |
| req_connect | input | 1 | Open actively toward `rem_ip_i`:`rem_port_i` |
| req_close | input | 1 | Close an established connection |
| loc_port_i | input | 16 | Local port to use for the next open |
| rem_ip_i | input | 32 | Remote IPv4 address for an active open |
| rem_port_i | input | 16 | Remote port for an active open |
| ev_syn | input | 1 | Parser saw a SYN |
| ev_synack | input | 1 | Parser saw a SYN-ACK |
| ev_ack | input | 1 | Parser saw an ACK |
| ev_fin | input | 1 | Parser saw a FIN |
| ev_rst | input | 1 | Parser saw an RST |
| ev_data | input | 1 | Parser saw payload data |
| seg_unacked | input | 1 | Transmit side holds an unacknowledged data segment |
| st_idle | output | 1 | Status: idle |
| st_listening | output | 1 | Status: listening |
| st_connecting | output | 1 | Status: handshake in progress |
| st_connected | output | 1 | Status: established |
| st_disconnecting | output | 1 | Status: close in progress |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 3 | Command code, see R11 |
| conn_loc_port | output | 16 | Latched local port |
| conn_rem_ip | output | 32 | Latched remote address |
| conn_rem_port | output | 16 | Latched remote port |

## Verification
The assertions check on every cycle the properties that involve only one or two cycles:
- the one-hot status;
- the immediate state and command that follow a connect, listen or close request, or a received RST;
- that an RST command always lands in idle, that probes occur only while connected, and that a strobe always carries a code.

The long timing rules need the bench's scenarios. These are the exact cycle at which the handshake or close deadline fires, the spacing and count of retransmissions before abort, the probe period and how a received event restarts it, the probe retry limit, and the delayed acknowledgement. The bench counts cycles between command pulses and compares them with the parameter values.

// File: rtl/tcpsup_pkg.sv
// Shared types for the TCP connection supervisor.
// Assumes: a single clock domain; the codes below are decoded by the segment builder.
package tcpsup_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_LISTEN   = 3'd1,
        S_SYN_RCVD = 3'd2,
        S_SYN_SENT = 3'd3,
        S_ESTAB    = 3'd4,
        S_CLOSING  = 3'd5
    } conn_state_t;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_SYN    = 3'd1,
        CMD_SYNACK = 3'd2,
        CMD_ACK    = 3'd3,
        CMD_FIN    = 3'd4,
        CMD_RST    = 3'd5,
        CMD_PROBE  = 3'd6,
        CMD_RETX   = 3'd7
    } seg_cmd_t;

endpackage

// File: rtl/sat_timer.sv
// Saturating tick timer.
// Counts up while run is high and stops at LIMIT. done stays high until clr.
// clr has priority over run.
// Assumes: LIMIT >= 1.
module sat_timer #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    assign done = (cnt == W'(LIMIT));

    // Count ticks, clear on request, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (run && !done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/try_counter.sv
// Retry counter.
// Counts issued retries and flags when MAX have been used.
// Saturates at MAX. clr has priority over inc.
// Assumes: MAX >= 1.
module try_counter #(
    parameter int MAX = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic spent
);
    localparam int W = $clog2(MAX + 1);

    logic [W-1:0] cnt;

    assign spent = (cnt == W'(MAX));

    // Track the number of retries since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && !spent) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tcp_conn_supervisor.sv
// TCP connection supervisor.
// Single-connection life-cycle FSM with a handshake/close deadline, retransmission
// with a retry abort, keepalive probing with its own retry abort, and a delayed pure ACK.
// Assumes: parser events are single-cycle pulses; one command is issued per cycle;
// a timer that expires while a higher-priority command is issued stays expired
// and is served on a later cycle.
module tcp_conn_supervisor
    import tcpsup_pkg::*;
#(
    parameter int CONN_TICKS  = 125_000_000,
    parameter int RETX_TICKS  = 1_250_000,
    parameter int RETX_TRIES  = 5,
    parameter bit KA_EN       = 1'b1,
    parameter int KA_PERIOD   = 625_000_000,
    parameter int KA_INTERVAL = 12_500_000,
    parameter int KA_TRIES    = 5,
    parameter int ACK_TICKS   = 125_000,
    parameter int PORT_W      = 16,
    parameter int ADDR_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_listen,
    input  logic              req_connect,
    input  logic              req_close,
    input  logic [PORT_W-1:0] loc_port_i,
    input  logic [ADDR_W-1:0] rem_ip_i,
    input  logic [PORT_W-1:0] rem_port_i,
    input  logic              ev_syn,
    input  logic              ev_synack,
    input  logic              ev_ack,
    input  logic              ev_fin,
    input  logic              ev_rst,
    input  logic              ev_data,
    input  logic              seg_unacked,
    output logic              st_idle,
    output logic              st_listening,
    output logic              st_connecting,
    output logic              st_connected,
    output logic              st_disconnecting,
    output logic              cmd_valid,
    output logic [2:0]        cmd_code,
    output logic [PORT_W-1:0] conn_loc_port,
    output logic [ADDR_W-1:0] conn_rem_ip,
    output logic [PORT_W-1:0] conn_rem_port
);
    conn_state_t state_q, nxt;
    seg_cmd_t    cmd_q, cmd_d;
    logic        ack_pend_q, ka_probe_q;
    logic        chg, in_conn, rx_any;
    logic        retx_run, ka_per_run, ka_int_run, ack_run;
    logic        conn_done, retx_done, ka_per_done, ka_int_done, ack_done;
    logic        retx_spent, ka_spent;
    logic        retx_issue, ka_issue, ack_issue;

    assign in_conn    = (state_q == S_SYN_SENT) || (state_q == S_SYN_RCVD) || (state_q == S_CLOSING);
    assign rx_any     = ev_syn | ev_synack | ev_ack | ev_fin | ev_data;
    assign chg        = (nxt != state_q);
    assign retx_run   = in_conn || ((state_q == S_ESTAB) && seg_unacked);
    assign ka_per_run = (state_q == S_ESTAB) && KA_EN && !ka_probe_q;
    assign ka_int_run = (state_q == S_ESTAB) && ka_probe_q;
    assign ack_run    = (state_q == S_ESTAB) && ack_pend_q;

    // Deadline for finishing a handshake or a close.
    sat_timer #(.LIMIT(CONN_TICKS)) u_conn_tmr (
        .clk(clk), .rst_n(rst_n), .clr(!in_conn || chg), .run(in_conn), .done(conn_done));

    // Retransmission interval and retry budget.
    sat_timer #(.LIMIT(RETX_TICKS)) u_retx_tmr (
        .clk(clk), .rst_n(rst_n), .clr(!retx_run || retx_issue || ev_ack || chg),
        .run(retx_run), .done(retx_done));
    try_counter #(.MAX(RETX_TRIES)) u_retx_try (
        .clk(clk), .rst_n(rst_n), .clr(ev_ack || chg || (state_q == S_IDLE)),
        .inc(retx_issue), .spent(retx_spent));

    // Keepalive idle period, probe repeat interval and probe retry budget.
    sat_timer #(.LIMIT(KA_PERIOD)) u_ka_per_tmr (
        .clk(clk), .rst_n(rst_n), .clr(!ka_per_run || rx_any || ka_issue || chg),
        .run(ka_per_run), .done(ka_per_done));
    sat_timer #(.LIMIT(KA_INTERVAL)) u_ka_int_tmr (
        .clk(clk), .rst_n(rst_n), .clr(!ka_int_run || rx_any || ka_issue || chg),
        .run(ka_int_run), .done(ka_int_done));
    try_counter #(.MAX(KA_TRIES)) u_ka_try (
        .clk(clk), .rst_n(rst_n), .clr(rx_any || (state_q != S_ESTAB)),
        .inc(ka_issue && ka_probe_q), .spent(ka_spent));

    // Delayed pure acknowledgement of received data.
    sat_timer #(.LIMIT(ACK_TICKS)) u_ack_tmr (
        .clk(clk), .rst_n(rst_n), .clr(!ack_run || ev_data || ack_issue),
        .run(ack_run), .done(ack_done));

    // Next state and the single command for this cycle, in priority order.
    always_comb begin
        nxt        = state_q;
        cmd_d      = CMD_NONE;
        retx_issue = 1'b0;
        ka_issue   = 1'b0;
        ack_issue  = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (req_connect) begin
                    nxt   = S_SYN_SENT;
                    cmd_d = CMD_SYN;
                end else if (req_listen) begin
                    nxt = S_LISTEN;
                end
            end
            S_LISTEN: begin
                if (ev_rst) begin
                    nxt = S_IDLE;
                end else if (ev_syn) begin
                    nxt   = S_SYN_RCVD;
                    cmd_d = CMD_SYNACK;
                end
            end
            S_SYN_RCVD, S_SYN_SENT, S_CLOSING: begin
                if (ev_rst) begin
                    nxt = S_IDLE;
                end else if (state_q == S_SYN_RCVD && ev_ack) begin
                    nxt = S_ESTAB;
                end else if (state_q == S_SYN_SENT && ev_synack) begin
                    nxt   = S_ESTAB;
                    cmd_d = CMD_ACK;
                end else if (state_q == S_CLOSING && ev_fin) begin
                    nxt   = S_IDLE;
                    cmd_d = CMD_ACK;
                end else if (state_q == S_CLOSING && ev_ack) begin
                    nxt = S_IDLE;
                end else if (conn_done) begin
                    nxt   = S_IDLE;
                    cmd_d = CMD_RST;
                end else if (retx_done && !ev_ack) begin
                    if (retx_spent) begin
                        nxt   = S_IDLE;
                        cmd_d = CMD_RST;
                    end else begin
                        cmd_d      = CMD_RETX;
                        retx_issue = 1'b1;
                    end
                end
            end
            S_ESTAB: begin
                if (ev_rst) begin
                    nxt = S_IDLE;
                end else if (ev_fin || req_close) begin
                    nxt   = S_CLOSING;
                    cmd_d = CMD_FIN;
                end else if (retx_done && !ev_ack) begin
                    if (retx_spent) begin
                        nxt   = S_IDLE;
                        cmd_d = CMD_RST;
                    end else begin
                        cmd_d      = CMD_RETX;
                        retx_issue = 1'b1;
                    end
                end else if (!rx_any && !ka_probe_q && ka_per_done) begin
                    cmd_d    = CMD_PROBE;
                    ka_issue = 1'b1;
                end else if (!rx_any && ka_int_done) begin
                    if (ka_spent) begin
                        nxt   = S_IDLE;
                        cmd_d = CMD_RST;
                    end else begin
                        cmd_d    = CMD_PROBE;
                        ka_issue = 1'b1;
                    end
                end else if (ack_done && !ev_data) begin
                    cmd_d     = CMD_ACK;
                    ack_issue = 1'b1;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // State, command strobe and per-connection flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            cmd_q      <= CMD_NONE;
            ack_pend_q <= 1'b0;
            ka_probe_q <= 1'b0;
        end else begin
            state_q <= nxt;
            cmd_q   <= cmd_d;
            if (nxt != S_ESTAB)  ack_pend_q <= 1'b0;
            else if (ev_data)    ack_pend_q <= 1'b1;
            else if (ack_issue)  ack_pend_q <= 1'b0;
            if (nxt != S_ESTAB || rx_any) ka_probe_q <= 1'b0;
            else if (ka_issue)            ka_probe_q <= 1'b1;
        end
    end

    // Latch the connection endpoints when an open is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn_loc_port <= '0;
            conn_rem_ip   <= '0;
            conn_rem_port <= '0;
        end else if (state_q == S_IDLE && req_connect) begin
            conn_loc_port <= loc_port_i;
            conn_rem_ip   <= rem_ip_i;
            conn_rem_port <= rem_port_i;
        end else if (state_q == S_IDLE && req_listen) begin
            conn_loc_port <= loc_port_i;
            conn_rem_ip   <= '0;
            conn_rem_port <= '0;
        end
    end

    assign st_idle          = (state_q == S_IDLE);
    assign st_listening     = (state_q == S_LISTEN);
    assign st_connecting    = (state_q == S_SYN_SENT) || (state_q == S_SYN_RCVD);
    assign st_connected     = (state_q == S_ESTAB);
    assign st_disconnecting = (state_q == S_CLOSING);
    assign cmd_valid        = (cmd_q != CMD_NONE);
    assign cmd_code         = cmd_q;
endmodule

// Checker: cycle-level properties of the supervisor's ports.
// Assumes: attached through the bind below; reset is active low.
module tcp_conn_supervisor_chk
    import tcpsup_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_listen,
    input logic       req_connect,
    input logic       req_close,
    input logic       ev_fin,
    input logic       ev_rst,
    input logic       st_idle,
    input logic       st_listening,
    input logic       st_connecting,
    input logic       st_connected,
    input logic       st_disconnecting,
    input logic       cmd_valid,
    input logic [2:0] cmd_code
);
    assert_status_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({st_idle, st_listening, st_connecting, st_connected, st_disconnecting}) == 1);

    assert_listen_passive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_idle && req_listen && !req_connect |=> st_listening && !cmd_valid);

    assert_connect_syn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_idle && req_connect |=> st_connecting && cmd_valid && cmd_code == 3'(CMD_SYN));

    assert_close_fin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_connected && req_close && !ev_rst && !ev_fin
        |=> st_disconnecting && cmd_valid && cmd_code == 3'(CMD_FIN));

    assert_abort_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_code == 3'(CMD_RST) |-> st_idle);

    assert_probe_connected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_code == 3'(CMD_PROBE) |-> st_connected);

    assert_peer_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_idle && ev_rst |=> st_idle && !cmd_valid);

    assert_strobe_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_code != 3'(CMD_NONE));
endmodule

bind tcp_conn_supervisor tcp_conn_supervisor_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_listen(req_listen), .req_connect(req_connect),
    .req_close(req_close), .ev_fin(ev_fin), .ev_rst(ev_rst), .st_idle(st_idle),
    .st_listening(st_listening), .st_connecting(st_connecting), .st_connected(st_connected),
    .st_disconnecting(st_disconnecting), .cmd_valid(cmd_valid), .cmd_code(cmd_code));

// File: tb/tb_tcp_conn_supervisor.sv
`timescale 1ns/1ps
module tb_tcp_conn_supervisor;
    localparam int CONN = 50, RETX = 20, RTRY = 3, KAP = 100, KAI = 10, KTRY = 2, ACKT = 30;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_listen = 0, req_connect = 0, req_close = 0;
    logic ev_syn = 0, ev_synack = 0, ev_ack = 0, ev_fin = 0, ev_rst = 0, ev_data = 0;
    logic seg_unacked = 0;
    logic [15:0] loc_port_i = '0, rem_port_i = '0;
    logic [31:0] rem_ip_i = '0;
    logic st_idle, st_listening, st_connecting, st_connected, st_disconnecting;
    logic cmd_valid;
    logic [2:0] cmd_code;
    logic [15:0] conn_loc_port, conn_rem_port;
    logic [31:0] conn_rem_ip;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    tcp_conn_supervisor #(.CONN_TICKS(CONN), .RETX_TICKS(RETX), .RETX_TRIES(RTRY), .KA_EN(1'b1),
        .KA_PERIOD(KAP), .KA_INTERVAL(KAI), .KA_TRIES(KTRY), .ACK_TICKS(ACKT)) dut (
        .clk(clk), .rst_n(rst_n), .req_listen(req_listen), .req_connect(req_connect),
        .req_close(req_close), .loc_port_i(loc_port_i), .rem_ip_i(rem_ip_i), .rem_port_i(rem_port_i),
        .ev_syn(ev_syn), .ev_synack(ev_synack), .ev_ack(ev_ack), .ev_fin(ev_fin), .ev_rst(ev_rst),
        .ev_data(ev_data), .seg_unacked(seg_unacked), .st_idle(st_idle), .st_listening(st_listening),
        .st_connecting(st_connecting), .st_connected(st_connected), .st_disconnecting(st_disconnecting),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .conn_loc_port(conn_loc_port),
        .conn_rem_ip(conn_rem_ip), .conn_rem_port(conn_rem_port));

    // Input bits {listen, connect, close, syn, synack, ack, fin, rst, data}
    // Status bits {idle, listening, connecting, connected, disconnecting}; cmd {valid, code}
    localparam logic [17:0] VECS [15] = '{
        {9'b100000000, 5'b01000, 4'b0000},  // R2 listen
        {9'b000100000, 5'b00100, 4'b1010},  // R2 syn -> SYN-ACK
        {9'b000001000, 5'b00010, 4'b0000},  // R2 ack -> connected
        {9'b000000001, 5'b00010, 4'b0000},  // R9 data, no immediate ACK
        {9'b000000100, 5'b00001, 4'b1100},  // R4 peer FIN -> FIN
        {9'b000001000, 5'b10000, 4'b0000},  // R4 ack -> idle
        {9'b010000000, 5'b00100, 4'b1001},  // R3 connect -> SYN
        {9'b000010000, 5'b00010, 4'b1011},  // R3 synack -> ACK
        {9'b001000000, 5'b00001, 4'b1100},  // R4 close -> FIN
        {9'b000000100, 5'b10000, 4'b1011},  // R4 fin -> ACK, idle
        {9'b110000000, 5'b00100, 4'b1001},  // R3 connect beats listen
        {9'b000000010, 5'b10000, 4'b0000},  // R10 rst in connecting
        {9'b100000000, 5'b01000, 4'b0000},  // R2 listen again
        {9'b000000010, 5'b10000, 4'b0000},  // R10 rst in listening
        {9'b001000000, 5'b10000, 4'b0000}   // R4 close in idle ignored
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [8:0] v);
        {req_listen, req_connect, req_close, ev_syn, ev_synack, ev_ack, ev_fin, ev_rst, ev_data} = v;
        @(posedge clk);
        @(negedge clk);
        {req_listen, req_connect, req_close, ev_syn, ev_synack, ev_ack, ev_fin, ev_rst, ev_data} = '0;
    endtask

    // Cycles until the next command pulse, and its code.
    task automatic wait_cmd(output int n, output logic [2:0] code);
        n = 0;
        code = '0;
        while (n < 1000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (cmd_valid) begin
                code = cmd_code;
                break;
            end
        end
    endtask

    function automatic logic [4:0] status();
        return {st_idle, st_listening, st_connecting, st_connected, st_disconnecting};
    endfunction

    task automatic to_estab();
        step(9'b010000000);
        step(9'b000010000);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        logic [2:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset status", status(), 5'b10000);
        check("R1 reset cmd", cmd_valid, 1'b0);

        for (int i = 0; i < 15; i++) begin
            step(VECS[i][17:9]);
            check($sformatf("R1/R2/R3/R4/R10 vec %0d status", i), status(), VECS[i][8:4]);
            check($sformatf("R11 vec %0d cmd", i), {cmd_valid, cmd_code}, VECS[i][3:0]);
        end

        // R3 endpoint latch and R5/R6 deadline while connecting
        loc_port_i = 16'h1234; rem_ip_i = 32'hC0A8_0005; rem_port_i = 16'h0050;
        step(9'b010000000);
        check("R3 loc port", conn_loc_port, 16'h1234);
        check("R3 rem ip", conn_rem_ip, 32'hC0A8_0005);
        check("R3 rem port", conn_rem_port, 16'h0050);
        wait_cmd(n, c); check("R6 first retx gap", n, RETX + 1); check("R6 retx code", c, 3'd7);
        wait_cmd(n, c); check("R6 second retx gap", n, RETX + 1);
        wait_cmd(n, c); check("R5 connect deadline gap", n, CONN - 2 * (RETX + 1) + 1);
        check("R5 deadline code", c, 3'd5);
        check("R5 idle after abort", status(), 5'b10000);

        // R5 deadline while disconnecting
        to_estab();
        step(9'b001000000);
        wait_cmd(n, c); wait_cmd(n, c); wait_cmd(n, c);
        check("R5 close deadline gap", n, CONN - 2 * (RETX + 1) + 1);
        check("R5 close deadline code", c, 3'd5);
        check("R5 idle after close abort", status(), 5'b10000);

        // R6 retry budget on a data segment
        to_estab();
        seg_unacked = 1'b1;
        for (int k = 0; k < RTRY; k++) begin
            wait_cmd(n, c);
            check("R6 retx gap", n, RETX + 1);
            check("R6 retx code", c, 3'd7);
        end
        wait_cmd(n, c);
        check("R6 abort gap", n, RETX + 1);
        check("R6 abort code", c, 3'd5);
        check("R6 idle after abort", status(), 5'b10000);
        seg_unacked = 1'b0;

        // R9 delayed ACK, then R7 probe and R8 probe retries
        to_estab();
        step(9'b000000001);
        wait_cmd(n, c); check("R9 ack delay", n, ACKT + 1); check("R9 ack code", c, 3'd3);
        wait_cmd(n, c); check("R7 probe after idle", n, KAP + 1 - (ACKT + 1)); check("R7 probe code", c, 3'd6);
        for (int k = 0; k < KTRY; k++) begin
            wait_cmd(n, c);
            check("R8 probe gap", n, KAI + 1);
            check("R8 probe code", c, 3'd6);
        end
        wait_cmd(n, c);
        check("R8 probe abort gap", n, KAI + 1);
        check("R8 probe abort code", c, 3'd5);
        check("R8 idle after abort", status(), 5'b10000);

        // R7 a received event restarts the idle period
        to_estab();
        repeat (50) @(negedge clk);
        step(9'b000001000);
        wait_cmd(n, c);
        check("R7 reload probe gap", n, KAP + 1);
        check("R7 reload probe code", c, 3'd6);
        step(9'b000000010);
        check("R10 rst in connected", status(), 5'b10000);
        check("R10 no cmd on rst", cmd_valid, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule